// File: doc/BRIEF.md
# Peak-to-Average Ratio Reduction Engine

This block sits after the inverse transform in a multitone transmitter. It holds one time-domain symbol of real samples in a local buffer. It can lower the largest excursions of that symbol before the samples go on to windowing and cyclic extension. A stored correction waveform is built only from tones that carry no data. Each reduction pass finds the single largest sample whose magnitude is above a programmable limit. The pass then rotates the waveform so that its main lobe at index 0 lands on that sample, scales it by the amount the peak exceeds the limit, and subtracts it from every sample of the symbol.

A header bit loaded with the first sample of each symbol selects between processing and plain pass-through. The number of passes (0 to 7) and the magnitude limit are also taken with the first sample. If a pass finds no sample above the limit, the remaining passes are dropped and the symbol is sent at once. The result leaves in index order through a FIFO write port that waits while the FIFO reports full. The correction waveform is loaded through a simple write port before use.

Top module: `papr_engine`

## Requirements
- R1: During and directly after reset, `in_ready` is 1, and `fifo_wr_en` and `fifo_wr_last` are 0.
- R2: When the bypass bit taken with the first sample is 1, the 64 samples are written out unchanged and in order. The first write is visible one cycle after the last input sample is accepted.
- R3: A pass count of 0 gives the same output and the same one-cycle latency as bypass.
- R4: A pass selects the sample with the largest magnitude |x| that is strictly greater than the limit. On a tie, the lowest index is chosen.
- R5: The correction for sample n is c = (s·k + 2^14) >>> 15, an arithmetic shift. Here k is a signed Q1.15 waveform value and s = p − limit for a positive peak p, or s = p + limit for a negative peak p.
- R6: The waveform value used for sample n is the one at address (n − peak index) mod 64.
- R7: Each new sample x − c saturates to the signed 16-bit range [−32768, 32767].
- R8: Up to the configured number of passes run one after another, each on the result of the one before. A symbol that is processed takes more than 66 cycles from its last input to its first output.
- R9: If a pass finds no sample above the limit, no further passes run. The symbol is emitted with its first write visible 66 cycles after the last input sample is accepted.
- R10: Exactly 64 writes leave in index order. `fifo_wr_last` is 1 only on the 64th write. No write happens and the data is held while `fifo_full` is 1.
- R11: Samples are accepted only while `in_ready` is 1. Bypass bit, pass count and limit are taken with the first sample, and later changes to them within the symbol have no effect. `in_ready` stays 0 from the 64th accepted sample until the last output write, and samples offered in that time are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample is offered |
| in_sample | input | 16 | Signed input sample |
| in_bypass | input | 1 | Header bit, taken with the first sample: 1 passes the symbol through |
| in_ready | output | 1 | Engine accepts input samples |
| cfg_iters | input | 3 | Number of reduction passes, taken with the first sample |
| cfg_thresh | input | 16 | Unsigned magnitude limit, taken with the first sample |
| kern_we | input | 1 | Write strobe for the correction waveform |
| kern_addr | input | 6 | Waveform write address |
| kern_data | input | 16 | Signed Q1.15 waveform value |
| fifo_full | input | 1 | Downstream FIFO cannot accept a write |
| fifo_wr_en | output | 1 | Output sample write strobe |
| fifo_wr_data | output | 16 | Signed output sample |
| fifo_wr_last | output | 1 | Marks the 64th sample of the symbol |

## Verification
A wrong internal state shows up at the ports within one symbol. A mis-chosen peak index or scale changes almost every output sample of that symbol, because the shifted waveform is subtracted from all 64 positions. A wrong pass counter or early-exit decision shows up at once as a different first-write latency, and after more passes as a different set of sample values. A slip in the output index or in the stall handling breaks the sample order or the position of the last marker as soon as the FIFO holds off a write.

// File: rtl/papr_pkg.sv
// Shared types for the peak-to-average reduction engine.
// Assumes: nothing beyond the state encoding is shared between modules.
package papr_pkg;
    typedef enum logic [2:0] {
        ST_LOAD   = 3'd0,
        ST_SCAN   = 3'd1,
        ST_DECIDE = 3'd2,
        ST_SUB    = 3'd3,
        ST_EMIT   = 3'd4
    } papr_state_t;
endpackage

// File: rtl/papr_kernel_mem.sv
// Correction waveform store: one write port and one asynchronous read port.
// Assumes: contents are loaded before a symbol is processed and are not
// rewritten while the engine is busy. No reset: contents are data.
module papr_kernel_mem #(
    parameter int N    = 64,
    parameter int KW   = 16,
    localparam int AW  = $clog2(N)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [KW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [KW-1:0] rdata
);
    logic [KW-1:0] mem_q [N];

    // Store one waveform value per write strobe.
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Read the value addressed by the aligned index.
    always_comb begin
        rdata = mem_q[raddr];
    end
endmodule

// File: rtl/papr_peak_find.sv
// Sequential peak finder: one sample per cycle, keeps the largest magnitude
// that is strictly above the limit. A strict compare keeps the lowest index
// on ties. The compare base is the limit on the first sample of a scan.
// Assumes: samples arrive in ascending index order, and thr is stable
// for a whole scan.
module papr_peak_find #(
    parameter int W    = 16,
    parameter int IDXW = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    input  logic                first,
    input  logic [IDXW-1:0]     idx,
    input  logic signed [W-1:0] sample,
    input  logic [W-1:0]        thr,
    output logic                found,
    output logic [IDXW-1:0]     best_idx,
    output logic signed [W-1:0] best_val
);
    logic signed [W:0] ext;
    logic [W:0]        mag;
    logic [W:0]        base;
    logic [W:0]        best_mag_q;
    logic              hit;

    // Magnitude one bit wider so that the most negative value fits.
    always_comb begin
        ext  = {sample[W-1], sample};
        mag  = ext[W] ? (~ext + 1'b1) : ext;
        base = first ? {1'b0, thr} : best_mag_q;
        hit  = mag > base;
    end

    // Track the winning sample across one scan.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            found      <= 1'b0;
            best_mag_q <= '0;
            best_idx   <= '0;
            best_val   <= '0;
        end else if (step) begin
            if (hit) begin
                found      <= 1'b1;
                best_mag_q <= mag;
                best_idx   <= idx;
                best_val   <= sample;
            end else if (first) begin
                found      <= 1'b0;
                best_mag_q <= {1'b0, thr};
            end
        end
    end

    // A held winner mid-scan always exceeds the limit (R4).
    p_best_over_thr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !first && found) |-> (best_mag_q > {1'b0, thr}));
endmodule

// File: rtl/papr_sub_unit.sv
// Combinational correction: scale = peak minus signed limit, times a Q1.15
// waveform value, rounded half up, subtracted from the sample, saturated.
// Assumes: |peak| > thr whenever the result is used.
module papr_sub_unit #(
    parameter int W  = 16,
    parameter int KW = 16
) (
    input  logic signed [W-1:0]  sample,
    input  logic signed [W-1:0]  peak,
    input  logic [W-1:0]         thr,
    input  logic signed [KW-1:0] kern,
    output logic signed [W-1:0]  result
);
    localparam int SW = W + 2;
    localparam int PW = SW + KW;
    localparam logic signed [PW-1:0] HALF = PW'(1) << (KW - 2);
    localparam logic signed [PW-1:0] HI   = (PW'(1) << (W - 1)) - PW'(1);
    localparam logic signed [PW-1:0] LO   = ~HI;

    logic signed [SW-1:0] pk_e;
    logic signed [SW-1:0] th_e;
    logic signed [SW-1:0] scale;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] corr;
    logic signed [PW-1:0] diff;

    // Scale, round, subtract and clip in one combinational path.
    always_comb begin
        pk_e  = {{2{peak[W-1]}}, peak};
        th_e  = {2'b00, thr};
        scale = peak[W-1] ? (pk_e + th_e) : (pk_e - th_e);
        prod  = PW'(scale) * PW'(kern);
        corr  = (prod + HALF) >>> (KW - 1);
        diff  = {{(PW-W){sample[W-1]}}, sample} - corr;
        if (diff > HI) begin
            result = HI[W-1:0];
        end else if (diff < LO) begin
            result = LO[W-1:0];
        end else begin
            result = diff[W-1:0];
        end
    end
endmodule

// File: rtl/papr_engine.sv
// Peak-to-average reduction engine top. Loads a 64-sample symbol, runs up
// to cfg_iters passes of scan / decide / subtract, then streams the buffer
// to a FIFO write port. Header and configuration are taken with sample 0.
// Assumes: N is a power of two (circular alignment wraps the index), and
// the waveform memory is loaded while the engine waits for input.
module papr_engine #(
    parameter int N    = 64,
    parameter int W    = 16,
    parameter int KW   = 16,
    parameter int ITW  = 3,
    localparam int IDXW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [W-1:0]    in_sample,
    input  logic            in_bypass,
    output logic            in_ready,
    input  logic [ITW-1:0]  cfg_iters,
    input  logic [W-1:0]    cfg_thresh,
    input  logic            kern_we,
    input  logic [IDXW-1:0] kern_addr,
    input  logic [KW-1:0]   kern_data,
    input  logic            fifo_full,
    output logic            fifo_wr_en,
    output logic [W-1:0]    fifo_wr_data,
    output logic            fifo_wr_last
);
    import papr_pkg::*;

    papr_state_t         state;
    logic [IDXW-1:0]     idx;
    logic signed [W-1:0] buf_q [N];
    logic                byp_q;
    logic [ITW-1:0]      left_q;
    logic [W-1:0]        thr_q;
    logic                last_idx;
    logic                accept;
    logic                skip;
    logic signed [W-1:0] cur;
    logic                pf_found;
    logic [IDXW-1:0]     pf_idx;
    logic signed [W-1:0] pf_val;
    logic [IDXW-1:0]     kaddr;
    logic [KW-1:0]       kval;
    logic signed [W-1:0] sub_res;

    // Handshake, index decode and the decision to skip processing.
    always_comb begin
        last_idx = (idx == IDXW'(N - 1));
        in_ready = (state == ST_LOAD);
        accept   = in_valid && in_ready;
        cur      = buf_q[idx];
        kaddr    = idx - pf_idx;
        if (idx == '0) begin
            skip = in_bypass || (cfg_iters == '0);
        end else begin
            skip = byp_q || (left_q == '0);
        end
    end

    papr_kernel_mem #(.N(N), .KW(KW)) u_kmem (
        .clk   (clk),
        .we    (kern_we),
        .waddr (kern_addr),
        .wdata (kern_data),
        .raddr (kaddr),
        .rdata (kval)
    );

    papr_peak_find #(.W(W), .IDXW(IDXW)) u_find (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (state == ST_SCAN),
        .first    (idx == '0),
        .idx      (idx),
        .sample   (cur),
        .thr      (thr_q),
        .found    (pf_found),
        .best_idx (pf_idx),
        .best_val (pf_val)
    );

    papr_sub_unit #(.W(W), .KW(KW)) u_sub (
        .sample (cur),
        .peak   (pf_val),
        .thr    (thr_q),
        .kern   ($signed(kval)),
        .result (sub_res)
    );

    // Sample buffer: filled on load, rewritten in place during subtraction.
    always_ff @(posedge clk) begin
        if (accept) begin
            buf_q[idx] <= $signed(in_sample);
        end else if (state == ST_SUB) begin
            buf_q[idx] <= sub_res;
        end
    end

    // Control sequence: load, scan, decide, subtract, emit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_LOAD;
            idx    <= '0;
            byp_q  <= 1'b0;
            left_q <= '0;
            thr_q  <= '0;
        end else begin
            case (state)
                ST_LOAD: begin
                    if (accept) begin
                        if (idx == '0) begin
                            byp_q  <= in_bypass;
                            left_q <= cfg_iters;
                            thr_q  <= cfg_thresh;
                        end
                        idx <= idx + 1'b1;
                        if (last_idx) begin
                            state <= skip ? ST_EMIT : ST_SCAN;
                        end
                    end
                end
                ST_SCAN: begin
                    idx <= idx + 1'b1;
                    if (last_idx) begin
                        state <= ST_DECIDE;
                    end
                end
                ST_DECIDE: begin
                    state <= pf_found ? ST_SUB : ST_EMIT;
                end
                ST_SUB: begin
                    idx <= idx + 1'b1;
                    if (last_idx) begin
                        left_q <= left_q - ITW'(1);
                        state  <= (left_q == ITW'(1)) ? ST_EMIT : ST_SCAN;
                    end
                end
                ST_EMIT: begin
                    if (!fifo_full) begin
                        idx <= idx + 1'b1;
                        if (last_idx) begin
                            state <= ST_LOAD;
                        end
                    end
                end
                default: state <= ST_LOAD;
            endcase
        end
    end

    // FIFO write port driven straight from the buffer.
    always_comb begin
        fifo_wr_en   = (state == ST_EMIT) && !fifo_full;
        fifo_wr_data = cur;
        fifo_wr_last = fifo_wr_en && last_idx;
    end

    // A scan only starts with passes left (R8).
    p_scan_has_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN) |-> (left_q != '0));

    // Subtraction only follows a scan that found a peak (R9).
    p_sub_needs_peak_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUB) |-> pf_found);

    // The alignment point is held for a whole subtraction pass (R6).
    p_peak_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUB && $past(state) == ST_SUB) |-> $stable(pf_idx));

    // A full FIFO holds the output sample and the emit phase (R10).
    p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMIT && fifo_full) |=> (state == ST_EMIT && $stable(fifo_wr_data)));
endmodule

// File: tb/papr_engine_tb.sv
// Bench: vector table walked by one loop, then directed reset, stall and
// configuration-capture tests. Expected samples come from a bench model.
module papr_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_sample = '0;
    logic        in_bypass = 1'b0;
    logic        in_ready;
    logic [2:0]  cfg_iters = '0;
    logic [15:0] cfg_thresh = '0;
    logic        kern_we = 1'b0;
    logic [5:0]  kern_addr = '0;
    logic [15:0] kern_data = '0;
    logic        fifo_full = 1'b0;
    logic        fifo_wr_en;
    logic [15:0] fifo_wr_data;
    logic        fifo_wr_last;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int kern_m [64];
    int src [64];
    int expv [64];
    int got [64];
    int ocnt = 0;
    int last_pos = -1;
    int last_cnt = 0;
    int t_in = 0;
    int t_out = 0;
    bit saw_busy = 0;

    // Fields: pattern, bypass, passes, limit, latency kind, requirement.
    localparam int VEC [9][6] = '{
        '{0, 1, 5,   500, 0, 2},
        '{0, 0, 0,   500, 0, 3},
        '{0, 0, 1,  5000, 2, 5},
        '{0, 0, 3,  3000, 2, 8},
        '{1, 0, 2,  1000, 2, 6},
        '{4, 0, 1,  1000, 2, 4},
        '{3, 0, 1,   100, 2, 7},
        '{2, 0, 7, 20000, 1, 9},
        '{0, 0, 7,     0, 2, 8}
    };

    papr_engine u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .in_bypass(in_bypass), .in_ready(in_ready), .cfg_iters(cfg_iters),
        .cfg_thresh(cfg_thresh), .kern_we(kern_we), .kern_addr(kern_addr),
        .kern_data(kern_data), .fifo_full(fifo_full), .fifo_wr_en(fifo_wr_en),
        .fifo_wr_data(fifo_wr_data), .fifo_wr_last(fifo_wr_last)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Output collector, sampled away from the active edge.
    always @(negedge clk) begin
        if (fifo_wr_en) begin
            if (ocnt < 64) got[ocnt] = int'($signed(fifo_wr_data));
            if (ocnt == 0) t_out = cyc;
            if (fifo_wr_last) begin
                last_pos = ocnt;
                last_cnt = last_cnt + 1;
            end
            ocnt = ocnt + 1;
        end
    end

    initial begin
        #(4 * 150000);
        errors = errors + 1;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic string tag(input int r);
        case (r)
            2: tag = "R2";
            3: tag = "R3";
            4: tag = "R4";
            5: tag = "R5 R6";
            6: tag = "R6";
            7: tag = "R7";
            8: tag = "R8";
            9: tag = "R9";
            default: tag = "R10 R11";
        endcase
    endfunction

    function automatic int gen(input int pat, input int n);
        case (pat)
            0: gen = ((n * 997) % 20000) - 10000;
            1: gen = (n == 5) ? 30000 : (n == 40) ? -31000 : ((n * 311) % 2000) - 1000;
            2: gen = ((n * 37) % 1000) - 500;
            3: gen = (n == 10) ? -32768 : ((n % 2 == 0) ? 32000 : -32000);
            default: gen = (n == 7) ? 20000 : (n == 50) ? -20000 : 0;
        endcase
    endfunction

    // Reference model built from R4..R9.
    task automatic model(input int byp, input int iters, input int thr);
        for (int n = 0; n < 64; n++) expv[n] = src[n];
        if (byp == 0) begin
            for (int it = 0; it < iters; it++) begin
                int bm = thr;
                int bi = -1;
                int scale;
                for (int n = 0; n < 64; n++) begin
                    int m = (expv[n] < 0) ? -expv[n] : expv[n];
                    if (m > bm) begin
                        bm = m;
                        bi = n;
                    end
                end
                if (bi < 0) break;
                scale = (expv[bi] > 0) ? expv[bi] - thr : expv[bi] + thr;
                for (int n = 0; n < 64; n++) begin
                    longint p = longint'(scale) * longint'(kern_m[(n - bi) & 63]);
                    longint c = (p + 64'sd16384) >>> 15;
                    longint d = longint'(expv[n]) - c;
                    if (d > 32767) d = 32767;
                    if (d < -32768) d = -32768;
                    expv[n] = int'(d);
                end
            end
        end
    endtask

    task automatic send(input int byp, input int iters, input int thr, input bit scramble);
        @(posedge clk); #1;
        while (!in_ready) begin
            @(posedge clk); #1;
        end
        for (int n = 0; n < 64; n++) begin
            in_valid   = 1'b1;
            in_sample  = 16'(src[n]);
            in_bypass  = (n != 0 && scramble) ? ~byp[0] : byp[0];
            cfg_iters  = (n != 0 && scramble) ? ~3'(iters) : 3'(iters);
            cfg_thresh = (n != 0 && scramble) ? 16'(thr + 777) : 16'(thr);
            if (n == 63) t_in = cyc;
            @(posedge clk); #1;
        end
        in_valid = 1'b0;
    endtask

    task automatic run(input int pat, input int byp, input int iters, input int thr,
                       input bit scramble, input bit stall);
        int guard = 0;
        for (int n = 0; n < 64; n++) src[n] = gen(pat, n);
        model(byp, iters, thr);
        ocnt = 0;
        last_pos = -1;
        last_cnt = 0;
        saw_busy = 0;
        send(byp, iters, thr, scramble);
        while (ocnt < 64 && guard < 5000) begin
            if (!in_ready) saw_busy = 1;
            fifo_full = stall && (cyc % 3 == 0);
            if (stall) begin
                in_valid  = 1'b1;
                in_sample = 16'h7abc;
            end
            @(posedge clk); #1;
            guard++;
        end
        in_valid  = 1'b0;
        fifo_full = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_out(input string t);
        int bad = -1;
        checks++;
        for (int n = 0; n < 64; n++) if (bad < 0 && got[n] != expv[n]) bad = n;
        if (ocnt != 64 || last_pos != 63 || last_cnt != 1) begin
            errors++;
            $display("FAIL %s: writes %0d last at %0d (x%0d), expected 64 last at 63 (x1)",
                     t, ocnt, last_pos, last_cnt);
        end else if (bad >= 0) begin
            errors++;
            $display("FAIL %s: sample %0d actual %0d expected %0d", t, bad, got[bad], expv[bad]);
        end
    endtask

    task automatic check_lat(input int kind, input string t);
        int lat = t_out - t_in;
        checks++;
        if ((kind == 0 && lat != 1) || (kind == 1 && lat != 66) || (kind == 2 && lat <= 66)) begin
            errors++;
            $display("FAIL %s latency: actual %0d expected %s", t, lat,
                     kind == 0 ? "1" : kind == 1 ? "66" : ">66");
        end
    endtask

    initial begin
        kern_m[0] = 32767;
        for (int i = 1; i < 64; i++) kern_m[i] = ((i * 1237) % 4096) - 2048;

        repeat (3) @(posedge clk);
        #1;
        // R1: outputs during reset
        checks++;
        if (in_ready !== 1'b1 || fifo_wr_en !== 1'b0 || fifo_wr_last !== 1'b0) begin
            errors++;
            $display("FAIL R1 in reset: ready %b wr %b last %b, expected 1 0 0",
                     in_ready, fifo_wr_en, fifo_wr_last);
        end
        for (int i = 0; i < 64; i++) begin
            kern_we   = 1'b1;
            kern_addr = 6'(i);
            kern_data = 16'(kern_m[i]);
            @(posedge clk); #1;
        end
        kern_we = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs right after reset
        checks++;
        if (in_ready !== 1'b1 || fifo_wr_en !== 1'b0 || fifo_wr_last !== 1'b0) begin
            errors++;
            $display("FAIL R1 after reset: ready %b wr %b last %b, expected 1 0 0",
                     in_ready, fifo_wr_en, fifo_wr_last);
        end

        for (int v = 0; v < 9; v++) begin
            run(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], 1'b0, 1'b0);
            check_out(tag(VEC[v][5]));
            if (VEC[v][4] != 2 || VEC[v][5] == 8) check_lat(VEC[v][4], tag(VEC[v][5]));
        end

        // R7: saturated values reach the output
        run(3, 0, 1, 100, 1'b0, 1'b0);
        checks++;
        begin
            int sat = 0;
            for (int n = 0; n < 64; n++) if (got[n] == 32767 || got[n] == -32768) sat++;
            if (sat < 2) begin
                errors++;
                $display("FAIL R7: saturated outputs actual %0d expected >= 2", sat);
            end
        end

        // R10 R11: stalls, inputs offered while busy are ignored
        run(0, 0, 2, 2000, 1'b0, 1'b1);
        check_out("R10 R11 stall");
        checks++;
        if (!saw_busy) begin
            errors++;
            $display("FAIL R11: in_ready while busy actual 1 expected 0");
        end

        // R11: header and configuration changes after sample 0 have no effect
        run(1, 0, 3, 1500, 1'b1, 1'b0);
        check_out("R11 capture");
        run(0, 1, 4, 800, 1'b1, 1'b0);
        check_out("R11 R2 capture bypass");
        check_lat(0, "R11 R2");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule